// File: doc/BRIEF.md
# Telephony Codec Serial Port

This block links a processor register bus to an external 8-bit telephony codec over a full-duplex serial link. It divides the system clock down to a bit clock, marks the first bit of every 8-bit frame with a one-bit-wide sync pulse, and sends transmit bytes most significant bit first. At the same time it shifts in a received byte during every frame. Each direction has a 16-byte FIFO and its own enable. The host loads bytes to send and collects received bytes through a single data address.

An interrupt request is raised each time eight frames, which is half a FIFO, have gone by. At that point a receive FIFO that has been kept drained holds eight new bytes, and a transmit FIFO has room for eight more. The frame counter behind the interrupt starts when the first direction is switched on from idle. A direction that is enabled later is therefore not aligned with that cadence. A transmit FIFO that runs dry sends zero bytes and flags an underrun. A receive FIFO that is full drops the new byte and flags an overrun. Switching both directions off returns the whole port to idle.

Register map (3-bit address): 0 is DATA (a write pushes the transmit FIFO; a read pops the receive FIFO). 1 is CONTROL, read/write: bit0 receive enable, bit1 transmit enable, bit2 interrupt enable. 2 is FLAGS, read: bit0 interrupt pending, bit1 underrun, bit2 overrun. 3 is LEVELS, read: bit0 tx empty, bit1 tx at least half full, bit2 tx full, bit3 rx empty, bit4 rx at least half full, bit5 rx full. 4 is CLEAR, write: bit0 clears pending, bit1 clears underrun, bit2 clears overrun. Reads of any other address return zero.

Top module: `tel_codec_port`

## Requirements
- R1: While either enable is set, `bclk` is a square wave with a period of 2*HALF_DIV system clocks. While both enables are clear, `bclk`, `fsync` and `sdo` are held low.
- R2: `fsync` rises together with a rising `bclk` edge and stays high for exactly one bit period, covering bit 0 of every frame.
- R3: Transmit bytes leave in write order, most significant bit first, and `sdo` changes only on rising `bclk` edges.
- R4: `sdi` is sampled on falling `bclk` edges, most significant bit first. The byte is pushed into the receive FIFO at its last bit while receive is enabled. A DATA read returns received bytes in arrival order. A disabled direction holds its FIFO empty, and a DATA write made while transmit is disabled is ignored.
- R5: Each FIFO holds 16 bytes. A DATA write to a full transmit FIFO is dropped. LEVELS reports empty, at-least-half and full for both FIFOs.
- R6: If transmit is enabled and its FIFO is empty at a frame start, the frame carries 0x00 and the sticky underrun flag (FLAGS bit1) is set.
- R7: If a received byte completes while the receive FIFO is full, the byte is dropped, the sticky overrun flag (FLAGS bit2) is set, and the 16 bytes already stored are kept.
- R8: Interrupt pending (FLAGS bit0) is set at the end of every 8th frame, counted from the first frame after leaving idle, whichever direction was enabled first. The `irq` pin equals pending AND interrupt enable, one clock later.
- R9: A CLEAR write clears each flag whose bit is written as 1. `irq` falls within two clocks of the write.
- R10: Clearing both enables empties both FIFOs, restarts the frame count, and clears the pending, underrun and overrun flags.
- R11: `reg_rdata` is valid in the clock after `reg_rd`. A DATA read of an empty receive FIFO returns 0x00 and does not pop.
- R12: After reset all outputs are low, FLAGS reads 0x00 and LEVELS reads 0x09.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, level |
| bclk | output | 1 | Serial bit clock to codec |
| fsync | output | 1 | Frame sync pulse to codec |
| sdo | output | 1 | Serial data to codec |
| sdi | input | 1 | Serial data from codec |

## Verification
A wrong bit position or frame counter shows up on the serial pins within one frame: `fsync` lands on a bit other than bit 0, or the transmitted byte is rotated. A frame count that is off by one moves the `irq` rising edge by a whole frame, which is 16*HALF_DIV clocks, so it shows up at the first interrupt. FIFO pointer or level faults appear at the next DATA read as a byte that is wrong, repeated or missing. They also appear at the full or empty boundaries as a LEVELS bit or a sticky flag with the wrong value. A flush that leaves state behind is seen right after the port returns to idle, through LEVELS, FLAGS and `irq`.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_DATA  = 3'd0,
    REG_CTRL  = 3'd1,
    REG_FLAGS = 3'd2,
    REG_LEVEL = 3'd3,
    REG_CLEAR = 3'd4
  } tcp_reg_e;

  // packed: irq_en is bit2, tx_en bit1, rx_en bit0
  typedef struct packed {
    logic irq_en;
    logic tx_en;
    logic rx_en;
  } tcp_ctrl_t;
endpackage

// File: rtl/tcp_bitclk_gen.sv
module tcp_bitclk_gen #(
  parameter int HALF_DIV   = 576,
  parameter int FRAME_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic bclk,
  output logic fsync,
  output logic rise_tick,
  output logic fall_tick,
  output logic frame_start,
  output logic frame_end
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

  logic [DW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic          term;

  assign term = run && (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      bclk  <= 1'b0;
      fsync <= 1'b0;
      bit_q <= BIT_LAST;
    end else begin
      div_q <= term ? '0 : div_q + DW'(1);
      if (term) bclk <= ~bclk;
      if (term && !bclk) begin
        bit_q <= (bit_q == BIT_LAST) ? '0 : bit_q + BW'(1);
        fsync <= (bit_q == BIT_LAST);
      end
    end
  end

  assign rise_tick   = term && !bclk;
  assign fall_tick   = term && bclk;
  assign frame_start = rise_tick && (bit_q == BIT_LAST);
  assign frame_end   = fall_tick && (bit_q == BIT_LAST);
endmodule

// File: rtl/tcp_byte_fifo.sv
module tcp_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/tcp_irq_ctrl.sv
module tcp_irq_ctrl #(
  parameter int IRQ_FRAMES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic frame_end,
  input  logic irq_en,
  input  logic clr_pend,
  output logic pending,
  output logic irq
);
  localparam int CW = (IRQ_FRAMES > 1) ? $clog2(IRQ_FRAMES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(IRQ_FRAMES - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = frame_end && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      if (frame_end) cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CW'(1);
      if (wrap)          pending <= 1'b1;
      else if (clr_pend) pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pending && irq_en;
  end
endmodule

// File: rtl/tel_codec_port.sv
module tel_codec_port
  import tcp_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int HALF_DIV   = 576
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic [FRAME_BITS-1:0] reg_wdata,
  input  logic                  reg_rd,
  output logic [FRAME_BITS-1:0] reg_rdata,
  output logic                  irq,
  output logic                  bclk,
  output logic                  fsync,
  output logic                  sdo,
  input  logic                  sdi
);
  localparam int LW         = $clog2(FIFO_DEPTH + 1);
  localparam int IRQ_FRAMES = FIFO_DEPTH / 2;
  localparam logic [LW-1:0] HALF_LVL = LW'(FIFO_DEPTH / 2);

  tcp_ctrl_t ctrl_q;
  logic rx_en, tx_en, irq_en, run;
  logic rise_tick, fall_tick, frame_start, frame_end;

  assign rx_en  = ctrl_q.rx_en;
  assign tx_en  = ctrl_q.tx_en;
  assign irq_en = ctrl_q.irq_en;
  assign run    = rx_en || tx_en;

  // host decode
  logic wr_data, wr_ctrl, wr_clear, rd_data;
  assign wr_data  = reg_wr && (reg_addr == REG_DATA);
  assign wr_ctrl  = reg_wr && (reg_addr == REG_CTRL);
  assign wr_clear = reg_wr && (reg_addr == REG_CLEAR);
  assign rd_data  = reg_rd && (reg_addr == REG_DATA);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= tcp_ctrl_t'(reg_wdata[2:0]);
  end

  tcp_bitclk_gen #(
    .HALF_DIV  (HALF_DIV),
    .FRAME_BITS(FRAME_BITS)
  ) u_clkgen (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .bclk       (bclk),
    .fsync      (fsync),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .frame_start(frame_start),
    .frame_end  (frame_end)
  );

  // transmit path
  logic [FRAME_BITS-1:0] tx_head, tx_sh;
  logic [LW-1:0]         tx_level;
  logic                  tx_empty, tx_full, tx_pop;

  assign tx_pop = frame_start && tx_en && !tx_empty;

  tcp_byte_fifo #(.W(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk  (clk),
    .rst  (rst),
    .flush(!tx_en),
    .push (wr_data && tx_en),
    .wdata(reg_wdata),
    .pop  (tx_pop),
    .rdata(tx_head),
    .level(tx_level),
    .empty(tx_empty),
    .full (tx_full)
  );

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      sdo   <= 1'b0;
      tx_sh <= '0;
    end else if (frame_start) begin
      if (!tx_empty) begin
        sdo   <= tx_head[FRAME_BITS-1];
        tx_sh <= tx_head << 1;
      end else begin
        sdo   <= 1'b0;
        tx_sh <= '0;
      end
    end else if (rise_tick) begin
      sdo   <= tx_sh[FRAME_BITS-1];
      tx_sh <= tx_sh << 1;
    end
  end

  // receive path
  logic [FRAME_BITS-1:0] rx_head, rx_sh, rx_byte;
  logic [LW-1:0]         rx_level;
  logic                  rx_empty, rx_full, rx_push;

  assign rx_byte = {rx_sh[FRAME_BITS-2:0], sdi};
  assign rx_push = frame_end && rx_en;

  always_ff @(posedge clk) begin
    if (rst || !rx_en)  rx_sh <= '0;
    else if (fall_tick) rx_sh <= rx_byte;
  end

  tcp_byte_fifo #(.W(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk  (clk),
    .rst  (rst),
    .flush(!rx_en),
    .push (rx_push),
    .wdata(rx_byte),
    .pop  (rd_data),
    .rdata(rx_head),
    .level(rx_level),
    .empty(rx_empty),
    .full (rx_full)
  );

  // sticky error flags
  logic underrun, overrun;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (frame_start && tx_en && tx_empty)     underrun <= 1'b1;
      else if (wr_clear && reg_wdata[1])        underrun <= 1'b0;
      if (rx_push && rx_full)                   overrun  <= 1'b1;
      else if (wr_clear && reg_wdata[2])        overrun  <= 1'b0;
    end
  end

  // interrupt cadence
  logic pending;

  tcp_irq_ctrl #(.IRQ_FRAMES(IRQ_FRAMES)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .frame_end(frame_end),
    .irq_en   (irq_en),
    .clr_pend (wr_clear && reg_wdata[0]),
    .pending  (pending),
    .irq      (irq)
  );

  // registered read mux
  logic [5:0] levels;
  assign levels = {rx_full, (rx_level >= HALF_LVL), rx_empty,
                   tx_full, (tx_level >= HALF_LVL), tx_empty};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        REG_DATA:  reg_rdata <= rx_empty ? '0 : rx_head;
        REG_CTRL:  reg_rdata <= FRAME_BITS'(ctrl_q);
        REG_FLAGS: reg_rdata <= FRAME_BITS'({overrun, underrun, pending});
        REG_LEVEL: reg_rdata <= FRAME_BITS'(levels);
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tcp_port_checker.sv
module tcp_port_checker (
  input logic clk,
  input logic rst,
  input logic run,
  input logic tx_en,
  input logic irq_en,
  input logic bclk,
  input logic fsync,
  input logic sdo,
  input logic irq,
  input logic pending,
  input logic overrun,
  input logic rx_full,
  input logic tx_empty,
  input logic rx_empty
);
  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> (!bclk && !fsync && !sdo)); // R1

  AST_SYNC_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |-> $rose(bclk)); // R2

  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (tx_en && $past(tx_en) && !$stable(sdo)) |-> $rose(bclk)); // R3

  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_full)); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(irq_en) && $past(pending))); // R8

  AST_IDLE_FLUSHED: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> (tx_empty && rx_empty && !pending && !overrun)); // R10
endmodule

bind tel_codec_port tcp_port_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (run),
  .tx_en   (tx_en),
  .irq_en  (irq_en),
  .bclk    (bclk),
  .fsync   (fsync),
  .sdo     (sdo),
  .irq     (irq),
  .pending (pending),
  .overrun (overrun),
  .rx_full (rx_full),
  .tx_empty(tx_empty),
  .rx_empty(rx_empty)
);

// File: tb/tel_codec_port_tb.sv
module tel_codec_port_tb;
  localparam int HALF = 8;
  localparam int BIT_PER = 2 * HALF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, bclk, fsync, sdo, sdi;

  assign sdi = sdo; // loopback

  always #2 clk = ~clk;

  tel_codec_port #(.FRAME_BITS(8), .FIFO_DEPTH(16), .HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq(irq), .bclk(bclk), .fsync(fsync), .sdo(sdo), .sdi(sdi)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard state
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] cur_exp = '0, mon_sh = '0;
  int  mon_cnt = 0, frames = 0, n_toggle = 0, cyc = 0, last_rise = -1, bclk_per = 0;
  bit  mon_synced = 0, rx_on = 0;
  logic prev_bclk = 0, prev_fsync = 0;

  always @(posedge clk) cyc++;

  // monitor: deserialise the transmit pin, compare against expected queue
  always @(negedge clk) begin
    if (!rst) begin
      if (bclk !== prev_bclk) n_toggle++;
      if (bclk && !prev_bclk) begin
        if (last_rise >= 0) bclk_per = cyc - last_rise;
        last_rise = cyc;
      end
      if (fsync && !prev_fsync) begin
        if (txq.size() > 0) cur_exp = txq.pop_front();
        else cur_exp = 8'h00;
      end
      if (!bclk && prev_bclk) begin
        if (!mon_synced && fsync) begin
          mon_synced = 1;
          mon_cnt = 0;
        end
        if (mon_synced) begin
          check("R2 fsync on bit 0 only", fsync, (mon_cnt == 0));
          mon_sh = {mon_sh[6:0], sdo};
          mon_cnt++;
          if (mon_cnt == 8) begin
            mon_cnt = 0;
            frames++;
            check("R3 serial byte", mon_sh, cur_exp);
            if (rx_on) rxq.push_back(mon_sh);
          end
        end
      end
    end
    prev_bclk  = bclk;
    prev_fsync = fsync;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic push_tx(input logic [7:0] d);
    wr(3'd0, d);
    txq.push_back(d);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R12 reset state
    check("R12 bclk", bclk, 0);
    check("R12 fsync", fsync, 0);
    check("R12 sdo", sdo, 0);
    check("R12 irq", irq, 0);
    rd(3'd2, v); check("R12 flags", v, 8'h00);
    rd(3'd3, v); check("R12 levels", v, 8'h09);

    // R1 idle: no bit clock; R4 write with transmit disabled ignored
    wr(3'd0, 8'h55);
    repeat (100) @(posedge clk);
    check("R1 idle toggles", n_toggle, 0);
    rd(3'd3, v); check("R4 tx fifo empty after ignored write", v[0], 1);

    // R8 cadence starts with receive; transmit joins three frames later
    frames = 0; rx_on = 1;
    wr(3'd1, 8'h05);
    wait (frames == 3);
    check("R1 bit clock period", bclk_per, BIT_PER);
    @(posedge fsync);
    wr(3'd1, 8'h07);
    push_tx(8'hA5); push_tx(8'h3C); push_tx(8'hFF); push_tx(8'h01); push_tx(8'h80);
    wait (irq == 1'b1);
    check("R8 irq after eighth frame", frames, 8);
    rd(3'd2, v); check("R8 pending flag", v[0], 1);
    wr(3'd4, 8'h01);
    repeat (2) @(negedge clk);
    check("R9 irq cleared", irq, 0);

    // R4 read back received bytes in order
    for (int i = 0; i < 8; i++) begin
      rd(3'd0, v);
      check("R4 received byte", v, rxq.pop_front());
    end

    // R6 underrun after five bytes are gone
    wait (frames == 11);
    rd(3'd2, v); check("R6 underrun flag", v[1], 1);
    wr(3'd4, 8'h02);
    rd(3'd2, v); check("R9 underrun cleared", v[1], 0);

    // R5 transmit fifo full, 17th write dropped; receive off
    rx_on = 0;
    wr(3'd1, 8'h06);
    rxq.delete();
    @(posedge fsync);
    for (int i = 0; i < 16; i++) push_tx(8'(i * 17 + 3));
    rd(3'd3, v);
    check("R5 tx full", v[2], 1);
    check("R5 tx half", v[1], 1);
    check("R4 rx held empty", v[3], 1);
    wr(3'd0, 8'hEE);
    wait (txq.size() == 0);
    repeat (3 * 16 * BIT_PER) @(posedge clk);
    rd(3'd3, v); check("R5 tx drained", v[0], 1);

    // R10 both off: idle and flushed
    wr(3'd1, 8'h00);
    mon_synced = 0;
    repeat (4) @(negedge clk);
    check("R10 irq low", irq, 0);
    rd(3'd3, v); check("R10 levels", v, 8'h09);
    rd(3'd2, v); check("R10 flags", v, 8'h00);

    // R7 overrun with interrupt disabled
    rxq.delete(); frames = 0; rx_on = 1;
    wr(3'd1, 8'h03);
    @(posedge fsync);
    for (int i = 0; i < 16; i++) push_tx(8'(8'hC1 + i * 5));
    wait (frames == 20);
    rd(3'd2, v);
    check("R7 overrun flag", v[2], 1);
    check("R8 pending without enable", v[0], 1);
    check("R8 irq gated off", irq, 0);
    rd(3'd3, v); check("R5 rx full", v[5], 1);
    @(posedge fsync);
    for (int i = 0; i < 16; i++) begin
      rd(3'd0, v);
      check("R7 kept byte", v, rxq.pop_front());
    end
    rd(3'd0, v); check("R11 empty read returns zero", v, 8'h00);
    wr(3'd4, 8'h04);
    rd(3'd2, v); check("R9 overrun cleared", v[2], 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule